// File: doc/BRIEF.md
# Masked Even-Lane Widening SIMD Multiplier

This block is a pipelined vector datapath unit. It takes two packed operands up to 512 bits wide, split into eight 64-bit lanes. In every lane it multiplies the unsigned 32-bit value in the lower half of that lane from each operand and writes the full 64-bit product into the whole lane. The upper 32-bit half of each lane in both operands plays no part in the result.

A control word selects one of three vector lengths (128, 256 or 512 bits), an optional per-lane write mask that either merges the old destination lane or clears it, and an optional broadcast of a single 64-bit scalar as the second multiplicand. A legacy mode takes the first multiplicand from the old destination value, works on 128 bits only and hands back destination bits 511:128 untouched. An operation is offered with a valid strobe. It leaves the unit exactly three cycles later, with its own valid strobe. A new operation can enter on every cycle and there is no backpressure.

Top module: `evenlane_mul`

## Requirements
- R1: In each active lane j (bits 64j+63:64j), the result is the zero-extended bits 64j+31:64j of opA times the zero-extended bits 64j+31:64j of opB. Bits 64j+63:64j+32 of both operands have no effect.
- R2: Products are unsigned. Operands of all ones (0xFFFFFFFF in a lane's low half) give 0xFFFFFFFE00000001 in that lane, with no sign extension.
- R3: vlenSel picks the length: 2'b00 is 128 bits (lanes 0-1), 2'b01 is 256 bits (lanes 0-3), and 2'b10 or 2'b11 is 512 bits (lanes 0-7). Outside legacy mode, every result bit at or above the selected length is zero.
- R4: With maskEnable=1 and zeroMasking=0, an active lane whose laneMask bit (bit j for lane j) is 0 returns the matching 64 bits of dstOld.
- R5: With maskEnable=1 and zeroMasking=1, an active lane whose laneMask bit is 0 returns zero.
- R6: With maskEnable=0, every active lane returns its product, whatever laneMask holds.
- R7: laneMask bits for lanes at or above the active lane count have no effect on the result.
- R8: With bcastEnable=1 (outside legacy mode), every lane uses bcastScalar[31:0] as its second multiplicand, and opB has no effect.
- R9: With legacyMode=1, lanes 0-1 multiply dstOld's lane low halves by opB's lane low halves. Result bits 511:128 equal dstOld[511:128]. opA, vlenSel, maskEnable, laneMask, zeroMasking and bcastEnable have no effect.
- R10: An operation sampled with inValid=1 at a rising edge shows on result with outValid=1 after the third rising edge, counting that edge as the first. Operations may be issued on consecutive cycles and come out in order.
- R11: A synchronous active-high rst clears all in-flight operations: outValid is 0 after any edge where rst was 1. Operations issued before that edge never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| inValid | input | 1 | Operation offered this cycle |
| opA | input | 512 | First packed operand |
| opB | input | 512 | Second packed operand |
| dstOld | input | 512 | Old destination value (merge source, legacy first operand) |
| laneMask | input | 8 | Per-lane write mask, bit j for lane j |
| vlenSel | input | 2 | Vector length select |
| legacyMode | input | 1 | 128-bit legacy mode |
| maskEnable | input | 1 | Apply laneMask |
| zeroMasking | input | 1 | Masked-off lanes become zero instead of merging |
| bcastEnable | input | 1 | Use bcastScalar as the second multiplicand in every lane |
| bcastScalar | input | 64 | Broadcast scalar (low 32 bits used) |
| outValid | output | 1 | Result valid |
| result | output | 512 | Result vector |

## Verification
The bench builds the unit with its package defaults: eight 64-bit lanes of 32-bit multiplicands and a 3-stage pipeline. At these values the full 512-bit width is in play, so lanes above each shorter length, mask bits for lanes past the active count, and legacy pass-through of bits 511:128 can all be observed. Because the bench issues back-to-back operations with random gaps and a reset in mid-flight, every pipeline stage holds a different operation at once, and any stage that loads on the wrong strobe or drops out of step becomes visible.

// File: rtl/evenlane_mul_pkg.sv
`timescale 1ns/1ps
package evenlane_mul_pkg;
  localparam int LANES        = 8;
  localparam int LANE_W       = 64;
  localparam int HALF_W       = LANE_W / 2;
  localparam int VEC_W        = LANES * LANE_W;
  localparam int SHORT_BITS   = 128;
  localparam int MID_BITS     = 256;
  localparam int SHORT_LANES  = SHORT_BITS / LANE_W;
  localparam int MID_LANES    = MID_BITS / LANE_W;
  localparam int LEGACY_LANES = SHORT_LANES;
  localparam int LANE_IDX_W   = $clog2(LANES + 1);

  typedef enum logic [1:0] {
    LANE_PROD = 2'd0,
    LANE_KEEP = 2'd1,
    LANE_ZERO = 2'd2
  } laneSel_e;

  typedef struct packed {
    logic                 loadIn;
    logic                 loadMul;
    logic                 loadOut;
    logic                 takeDst;
    logic                 takeBcast;
    laneSel_e [LANES-1:0] laneSel;
  } dpStrobe_t;

  function automatic logic [LANE_IDX_W-1:0] activeLanes(input logic [1:0] vlen,
                                                        input logic legacy);
    logic [LANE_IDX_W-1:0] n;
    if (legacy) begin
      n = LANE_IDX_W'(LEGACY_LANES);
    end else begin
      unique case (vlen)
        2'b00:   n = LANE_IDX_W'(SHORT_LANES);
        2'b01:   n = LANE_IDX_W'(MID_LANES);
        default: n = LANE_IDX_W'(LANES);
      endcase
    end
    return n;
  endfunction
endpackage

// File: rtl/evenlane_mul_lane.sv
`timescale 1ns/1ps
module evenlane_mul_lane
  import evenlane_mul_pkg::*;
(
  input  logic              clk,
  input  logic              ldIn,
  input  logic              ldMul,
  input  logic              ldOut,
  input  logic              takeDst,
  input  logic              takeBcast,
  input  laneSel_e          sel,
  input  logic [HALF_W-1:0] aLo,
  input  logic [HALF_W-1:0] bLo,
  input  logic [HALF_W-1:0] scalarLo,
  input  logic [LANE_W-1:0] dLane,
  output logic [LANE_W-1:0] resLane
);
  logic [HALF_W-1:0] mulX;
  logic [HALF_W-1:0] mulY;
  logic [LANE_W-1:0] oldS1;
  logic [LANE_W-1:0] prodS2;
  logic [LANE_W-1:0] oldS2;
  logic [LANE_W-1:0] resS3;

  // stage 1: operand pick
  always_ff @(posedge clk) begin
    if (ldIn) begin
      mulX  <= takeDst ? dLane[HALF_W-1:0] : aLo;
      mulY  <= takeBcast ? scalarLo : bLo;
      oldS1 <= dLane;
    end
  end

  // stage 2: widening unsigned multiply
  always_ff @(posedge clk) begin
    if (ldMul) begin
      prodS2 <= {{HALF_W{1'b0}}, mulX} * {{HALF_W{1'b0}}, mulY};
      oldS2  <= oldS1;
    end
  end

  // stage 3: write-back select
  always_ff @(posedge clk) begin
    if (ldOut) begin
      unique case (sel)
        LANE_PROD: resS3 <= prodS2;
        LANE_KEEP: resS3 <= oldS2;
        default:   resS3 <= '0;
      endcase
    end
  end

  assign resLane = resS3;
endmodule

// File: rtl/evenlane_mul_datapath.sv
`timescale 1ns/1ps
module evenlane_mul_datapath
  import evenlane_mul_pkg::*;
(
  input  logic                    clk,
  input  dpStrobe_t               strobe,
  input  logic [LANES*HALF_W-1:0] aEven,
  input  logic [LANES*HALF_W-1:0] bEven,
  input  logic [HALF_W-1:0]       scalarLo,
  input  logic [VEC_W-1:0]        dOld,
  output logic [VEC_W-1:0]        result
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    evenlane_mul_lane u_lane (
      .clk      (clk),
      .ldIn     (strobe.loadIn),
      .ldMul    (strobe.loadMul),
      .ldOut    (strobe.loadOut),
      .takeDst  (strobe.takeDst),
      .takeBcast(strobe.takeBcast),
      .sel      (strobe.laneSel[j]),
      .aLo      (aEven[j*HALF_W +: HALF_W]),
      .bLo      (bEven[j*HALF_W +: HALF_W]),
      .scalarLo (scalarLo),
      .dLane    (dOld[j*LANE_W +: LANE_W]),
      .resLane  (result[j*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/evenlane_mul_ctrl.sv
`timescale 1ns/1ps
module evenlane_mul_ctrl
  import evenlane_mul_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [LANES-1:0] laneMask,
  input  logic [1:0]       vlenSel,
  input  logic             legacyMode,
  input  logic             maskEnable,
  input  logic             zeroMasking,
  input  logic             bcastEnable,
  output dpStrobe_t        strobe,
  output logic             outValid
);
  logic             vS1, vS2, vS3;
  logic [LANES-1:0] maskS1;
  logic [1:0]       vlenS1;
  logic             legacyS1, maskEnS1, zeroS1;
  laneSel_e [LANES-1:0] selNext;
  laneSel_e [LANES-1:0] selS2;
  logic [LANE_IDX_W-1:0] laneCnt;

  // valid pipeline
  always_ff @(posedge clk) begin
    if (rst) begin
      vS1 <= 1'b0;
      vS2 <= 1'b0;
      vS3 <= 1'b0;
    end else begin
      vS1 <= inValid;
      vS2 <= vS1;
      vS3 <= vS2;
    end
  end

  // control fields follow the operation into stage 1
  always_ff @(posedge clk) begin
    if (inValid) begin
      maskS1   <= laneMask;
      vlenS1   <= vlenSel;
      legacyS1 <= legacyMode;
      maskEnS1 <= maskEnable;
      zeroS1   <= zeroMasking;
    end
  end

  assign laneCnt = activeLanes(vlenS1, legacyS1);

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      if (LANE_IDX_W'(j) >= laneCnt) begin
        selNext[j] = legacyS1 ? LANE_KEEP : LANE_ZERO;
      end else if (legacyS1 || !maskEnS1 || maskS1[j]) begin
        selNext[j] = LANE_PROD;
      end else begin
        selNext[j] = zeroS1 ? LANE_ZERO : LANE_KEEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (vS1) selS2 <= selNext;
  end

  always_comb begin
    strobe.loadIn    = inValid;
    strobe.loadMul   = vS1;
    strobe.loadOut   = vS2;
    strobe.takeDst   = legacyMode;
    strobe.takeBcast = bcastEnable && !legacyMode;
    strobe.laneSel   = selS2;
  end

  assign outValid = vS3;
endmodule

// File: rtl/evenlane_mul.sv
`timescale 1ns/1ps
module evenlane_mul
  import evenlane_mul_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  input  logic [VEC_W-1:0] dstOld,
  input  logic [LANES-1:0] laneMask,
  input  logic [1:0]       vlenSel,
  input  logic             legacyMode,
  input  logic             maskEnable,
  input  logic             zeroMasking,
  input  logic             bcastEnable,
  input  logic [LANE_W-1:0] bcastScalar,
  output logic             outValid,
  output logic [VEC_W-1:0] result
);
  dpStrobe_t               strobe;
  logic [LANES*HALF_W-1:0] aEven;
  logic [LANES*HALF_W-1:0] bEven;

  for (genvar j = 0; j < LANES; j++) begin : g_even
    assign aEven[j*HALF_W +: HALF_W] = opA[j*LANE_W +: HALF_W];
    assign bEven[j*HALF_W +: HALF_W] = opB[j*LANE_W +: HALF_W];
  end

  evenlane_mul_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .laneMask   (laneMask),
    .vlenSel    (vlenSel),
    .legacyMode (legacyMode),
    .maskEnable (maskEnable),
    .zeroMasking(zeroMasking),
    .bcastEnable(bcastEnable),
    .strobe     (strobe),
    .outValid   (outValid)
  );

  evenlane_mul_datapath u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .aEven   (aEven),
    .bEven   (bEven),
    .scalarLo(bcastScalar[HALF_W-1:0]),
    .dOld    (dstOld),
    .result  (result)
  );
endmodule

// File: rtl/evenlane_mul_chk.sv
`timescale 1ns/1ps
module evenlane_mul_chk
  import evenlane_mul_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [VEC_W-1:0]  opA,
  input logic [VEC_W-1:0]  opB,
  input logic [VEC_W-1:0]  dstOld,
  input logic [LANES-1:0]  laneMask,
  input logic [1:0]        vlenSel,
  input logic              legacyMode,
  input logic              maskEnable,
  input logic              zeroMasking,
  input logic              bcastEnable,
  input logic [LANE_W-1:0] bcastScalar,
  input logic              outValid,
  input logic [VEC_W-1:0]  result
);
  logic [1:0] sinceRst;
  logic       ripe;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end
  assign ripe = (sinceRst == 2'd3) && outValid;

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3))); // R10

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> !outValid); // R11

  AST_LANE0_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    (ripe && !$past(legacyMode, 3) && !$past(bcastEnable, 3) &&
     (!$past(maskEnable, 3) || $past(laneMask[0], 3)))
    |-> (result[LANE_W-1:0] ==
         {{HALF_W{1'b0}}, $past(opA[HALF_W-1:0], 3)} *
         {{HALF_W{1'b0}}, $past(opB[HALF_W-1:0], 3)})); // R1

  AST_ZERO_ABOVE_SHORT: assert property (@(posedge clk) disable iff (rst)
    (ripe && !$past(legacyMode, 3) && ($past(vlenSel, 3) == 2'b00))
    |-> (result[VEC_W-1:SHORT_BITS] == '0)); // R3

  AST_ZERO_ABOVE_MID: assert property (@(posedge clk) disable iff (rst)
    (ripe && !$past(legacyMode, 3) && ($past(vlenSel, 3) == 2'b01))
    |-> (result[VEC_W-1:MID_BITS] == '0)); // R3

  AST_MERGE_LANE0: assert property (@(posedge clk) disable iff (rst)
    (ripe && !$past(legacyMode, 3) && $past(maskEnable, 3) &&
     !$past(zeroMasking, 3) && !$past(laneMask[0], 3))
    |-> (result[LANE_W-1:0] == $past(dstOld[LANE_W-1:0], 3))); // R4

  AST_ZERO_LANE0: assert property (@(posedge clk) disable iff (rst)
    (ripe && !$past(legacyMode, 3) && $past(maskEnable, 3) &&
     $past(zeroMasking, 3) && !$past(laneMask[0], 3))
    |-> (result[LANE_W-1:0] == '0)); // R5

  AST_BCAST_LANE1: assert property (@(posedge clk) disable iff (rst)
    (ripe && !$past(legacyMode, 3) && $past(bcastEnable, 3) &&
     (!$past(maskEnable, 3) || $past(laneMask[1], 3)))
    |-> (result[2*LANE_W-1:LANE_W] ==
         {{HALF_W{1'b0}}, $past(opA[LANE_W+HALF_W-1:LANE_W], 3)} *
         {{HALF_W{1'b0}}, $past(bcastScalar[HALF_W-1:0], 3)})); // R8

  AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (rst)
    (ripe && $past(legacyMode, 3))
    |-> (result[VEC_W-1:SHORT_BITS] == $past(dstOld[VEC_W-1:SHORT_BITS], 3))); // R9
endmodule

bind evenlane_mul evenlane_mul_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .opA        (opA),
  .opB        (opB),
  .dstOld     (dstOld),
  .laneMask   (laneMask),
  .vlenSel    (vlenSel),
  .legacyMode (legacyMode),
  .maskEnable (maskEnable),
  .zeroMasking(zeroMasking),
  .bcastEnable(bcastEnable),
  .bcastScalar(bcastScalar),
  .outValid   (outValid),
  .result     (result)
);

// File: tb/evenlane_mul_bench.sv
`timescale 1ns/1ps
module evenlane_mul_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [511:0] opA = '0, opB = '0, dstOld = '0;
  logic [7:0]   laneMask = '0;
  logic [1:0]   vlenSel = 2'b10;
  logic         legacyMode = 1'b0, maskEnable = 1'b0, zeroMasking = 1'b0, bcastEnable = 1'b0;
  logic [63:0]  bcastScalar = '0;
  logic         outValid;
  logic [511:0] result;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  bit           qv[$];
  logic [511:0] qd[$];
  string        qt[$];
  string        curTag = "R11";

  always #2.5 clk = ~clk;

  evenlane_mul u_evenlane_mul (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB), .dstOld(dstOld),
    .laneMask(laneMask), .vlenSel(vlenSel), .legacyMode(legacyMode),
    .maskEnable(maskEnable), .zeroMasking(zeroMasking), .bcastEnable(bcastEnable),
    .bcastScalar(bcastScalar), .outValid(outValid), .result(result)
  );

  function automatic logic [511:0] refModel();
    logic [511:0] r;
    int act;
    r = '0;
    if (legacyMode) act = 2;
    else if (vlenSel == 2'b00) act = 2;
    else if (vlenSel == 2'b01) act = 4;
    else act = 8;
    for (int j = 0; j < 8; j++) begin
      longint unsigned x, y, p;
      x = legacyMode ? 64'(dstOld[64*j +: 32]) : 64'(opA[64*j +: 32]);
      y = (bcastEnable && !legacyMode) ? 64'(bcastScalar[31:0]) : 64'(opB[64*j +: 32]);
      p = x * y;
      if (j >= act) r[64*j +: 64] = legacyMode ? dstOld[64*j +: 64] : 64'd0;
      else if (legacyMode || !maskEnable || laneMask[j]) r[64*j +: 64] = p;
      else r[64*j +: 64] = zeroMasking ? 64'd0 : dstOld[64*j +: 64];
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  task automatic stepCycle();
    @(posedge clk);
    if (rst) begin
      for (int k = 0; k < qv.size(); k++) qv[k] = 1'b0;
      qv.push_back(1'b0);
    end else begin
      qv.push_back(inValid);
    end
    qd.push_back(refModel());
    qt.push_back(curTag);
    #1;
    cycles++;
    if (qv.size() == 3) begin
      bit ev;
      logic [511:0] ed;
      string et;
      ev = qv.pop_front();
      ed = qd.pop_front();
      et = qt.pop_front();
      total++;
      if (outValid !== ev) begin
        bad++;
        $display("FAIL %s valid: got=%0b exp=%0b", ev ? et : "R10", outValid, ev);
      end
      if (ev) begin
        for (int j = 0; j < 8; j++) begin
          total++;
          if (result[64*j +: 64] !== ed[64*j +: 64]) begin
            bad++;
            $display("FAIL %s lane%0d: got=%h exp=%h", et, j, result[64*j +: 64], ed[64*j +: 64]);
          end
        end
      end
    end
  endtask

  task automatic issue(input string tag, input logic [1:0] vl, input logic leg,
                       input logic men, input logic zm, input logic bc, input logic [7:0] m);
    curTag      = tag;
    inValid     = 1'b1;
    vlenSel     = vl;
    legacyMode  = leg;
    maskEnable  = men;
    zeroMasking = zm;
    bcastEnable = bc;
    laneMask    = m;
    opA         = rnd512();
    opB         = rnd512();
    dstOld      = rnd512();
    bcastScalar = {$urandom, $urandom};
    stepCycle();
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    for (int k = 0; k < n; k++) stepCycle();
  endtask

  initial begin
    for (int k = 0; k < 4; k++) stepCycle();
    // R11: reset state
    total++;
    if (outValid !== 1'b0) begin
      bad++;
      $display("FAIL R11 reset: got=%0b exp=0", outValid);
    end
    rst = 1'b0;
    idle(2);

    // R1: full length, odd halves random
    issue("R1", 2'b10, 0, 0, 0, 0, 8'h00);
    issue("R1", 2'b11, 0, 0, 0, 0, 8'h00);
    // R2: all-ones operands
    issue("R2", 2'b10, 0, 0, 0, 0, 8'h00);
    opA = '1; opB = '1;
    curTag = "R2";
    stepCycle();
    // R3: shorter lengths clear upper bits
    issue("R3", 2'b00, 0, 0, 0, 0, 8'h00);
    issue("R3", 2'b01, 0, 0, 0, 0, 8'h00);
    // R4 merge, R5 zero
    issue("R4", 2'b10, 0, 1, 0, 0, 8'hA5);
    issue("R5", 2'b10, 0, 1, 1, 0, 8'h5A);
    issue("R5", 2'b01, 0, 1, 1, 0, 8'h06);
    // R6: masking off, mask content irrelevant
    issue("R6", 2'b10, 0, 0, 1, 0, 8'h00);
    // R7: mask bits beyond active lanes ignored
    issue("R7", 2'b00, 0, 1, 0, 0, 8'hFD);
    issue("R7", 2'b01, 0, 1, 1, 0, 8'hF2);
    // R8: broadcast
    issue("R8", 2'b10, 0, 0, 0, 1, 8'h00);
    issue("R8", 2'b10, 0, 1, 0, 1, 8'h3C);
    // R9: legacy ignores mask, broadcast, length
    issue("R9", 2'b10, 1, 1, 1, 1, 8'h00);
    issue("R9", 2'b01, 1, 0, 0, 0, 8'hFF);
    idle(4);

    // R10: back-to-back and gapped random traffic
    for (int n = 0; n < 300; n++) begin
      issue("R10", 2'($urandom), 1'($urandom_range(0, 4) == 0), 1'($urandom),
            1'($urandom), 1'($urandom), 8'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(4);

    // R11: reset while operations are in flight
    issue("R11", 2'b10, 0, 0, 0, 0, 8'h00);
    issue("R11", 2'b10, 0, 0, 0, 0, 8'h00);
    inValid = 1'b1;
    rst = 1'b1;
    curTag = "R11";
    stepCycle();
    rst = 1'b0;
    inValid = 1'b0;
    idle(4);
    issue("R11", 2'b01, 0, 1, 0, 0, 8'h09);
    idle(4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule